// File: doc/BRIEF.md
# Attribute Table Stream Validator

The block watches a device attribute table as it streams in, one byte on each beat that carries `in_valid`. The table opens with a 16-byte table header: a little-endian 32-bit total length in bytes 0..3, a revision byte at 4, a checksum byte at 5, six reserved bytes and a 32-bit sequence number. A run of typed sub-structures follows it. Each sub-structure begins with a 4-byte header: a type byte, a byte that must be zero, and a little-endian 16-bit length that counts the whole sub-structure.

While the bytes arrive, the block checks each sub-structure header against the length rules for its type. It keeps a modulo-256 sum over every byte of the table. It also writes the byte offset and length of every accepted entry into a small index, which has `IDX_DEPTH` slots and can be read at any time. The byte that carries `in_last` closes the table. On the next cycle a one-cycle `done` pulse appears, together with a pass flag and a 3-bit error code. Both stay held until the next table ends. A new table may start on the beat right after a closing byte.

Top module: `attr_table_checker`

## Requirements
- R1: On the first byte of every table, index slot 0 is written with offset 0 and length 16, and `idx_count` becomes 1. Each accepted sub-structure then takes the next slot, holding its offset from the table start and its declared length.
- R2: Types 0, 1 and 4 must declare 24 bytes, type 2 must declare 20 and type 3 must declare 8. Any other value gives error code 3 (length mismatch).
- R3: Type 5 must declare at least 16 bytes, and the length minus 16 must be a multiple of 8. Otherwise error code 3 is raised.
- R4: A sub-structure length of zero gives error code 1.
- R5: A nonzero second byte in a sub-structure header gives error code 2.
- R6: A type byte above 5 gives error code 4.
- R7: If the stream ends part way through the table header or part way through a sub-structure, error code 5 (overrun) is raised.
- R8: If the 8-bit sum of all table bytes is not zero when the stream ends, error code 6 is raised.
- R9: A sub-structure that arrives when all `IDX_DEPTH` slots are used gives error code 7. It is not written, and `idx_count` never exceeds `IDX_DEPTH`.
- R10: Only the first error of a table is reported. When one header has several faults, the order of precedence is zero length, reserved byte, reserved type, length mismatch, index full.
- R11: After reset, `done`, `pass`, `err_code` and `idx_count` are 0. `done` pulses for exactly one cycle, the cycle after the closing byte is accepted. At that point `pass` is 1 exactly when `err_code` is 0 (no error). Both values hold until the next `done`.
- R12: A table that starts on the beat straight after a closing byte is checked from a clean state, so an earlier error has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A table byte is present on this beat |
| in_byte | input | 8 | Table byte |
| in_last | input | 1 | This byte closes the table |
| done | output | 1 | One-cycle pulse when the result is ready |
| pass | output | 1 | The last table had no error |
| err_code | output | 3 | Error code of the last table (0 means no error) |
| idx_count | output | $clog2(IDX_DEPTH+1) | Number of index slots written for the current table |
| idx_rd_addr | input | $clog2(IDX_DEPTH) | Index slot to read |
| idx_rd_off | output | OFF_W | Byte offset held in the selected slot |
| idx_rd_len | output | 16 | Length held in the selected slot |

## Verification
The verdict is registered on the clock edge that takes the closing byte, so `done`, `pass` and `err_code` are due one cycle after that byte is driven. Index slots and `idx_count` are updated on the edge that takes the first table byte or the last header byte of a sub-structure. The bench drives every byte on a falling edge and reads the verdict on the next falling edge after the closing byte, which is exactly one register stage later. Index contents are read combinationally after that same edge, so a stray extra register on any of these paths shows up as a mismatch.

// File: rtl/attr_table_checker.sv
module attr_table_checker #(
  parameter int IDX_DEPTH = 8,
  parameter int OFF_W = 16,
  localparam int AW = $clog2(IDX_DEPTH),
  localparam int CW = $clog2(IDX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code,
  output logic [CW-1:0]    idx_count,
  input  logic [AW-1:0]    idx_rd_addr,
  output logic [OFF_W-1:0] idx_rd_off,
  output logic [15:0]      idx_rd_len
);
  typedef enum logic [1:0] {PH_TOP, PH_SUBH, PH_BODY} phase_t;

  phase_t            ph;
  logic [OFF_W-1:0]  pos, sh_start;
  logic [1:0]        sh_cnt;
  logic [7:0]        sh_type, sh_rsvd, sh_lo, sum;
  logic [15:0]       rem;
  logic [2:0]        err, hdr_err, err_n;
  logic [OFF_W-1:0]  off_mem [IDX_DEPTH];
  logic [15:0]       len_mem [IDX_DEPTH];

  wire [15:0] new_len  = {in_byte, sh_lo};
  wire [7:0]  sum_n    = sum + in_byte;
  wire        hdr_beat = (ph == PH_SUBH) && (sh_cnt == 2'd3);
  wire        idx_full = (idx_count == CW'(IDX_DEPTH));
  wire        complete = ((ph == PH_TOP) && (pos == OFF_W'(15))) ||
                         (hdr_beat && (new_len <= 16'd4)) ||
                         ((ph == PH_BODY) && (rem == 16'd1));
  wire        wr_sub   = in_valid && hdr_beat && (hdr_err == 3'd0);

  assign idx_rd_off = off_mem[idx_rd_addr];
  assign idx_rd_len = len_mem[idx_rd_addr];

  always_comb begin
    hdr_err = 3'd0;
    if (new_len == 16'd0)      hdr_err = 3'd1;
    else if (sh_rsvd != 8'd0)  hdr_err = 3'd2;
    else if (sh_type > 8'd5)   hdr_err = 3'd4;
    else begin
      case (sh_type)
        8'd0, 8'd1, 8'd4: if (new_len != 16'd24) hdr_err = 3'd3;
        8'd2:             if (new_len != 16'd20) hdr_err = 3'd3;
        8'd3:             if (new_len != 16'd8)  hdr_err = 3'd3;
        default:          if (new_len < 16'd16 || new_len[2:0] != 3'd0) hdr_err = 3'd3;
      endcase
      if (hdr_err == 3'd0 && idx_full) hdr_err = 3'd7;
    end
  end

  always_comb begin
    err_n = err;
    if (err == 3'd0) begin
      if (hdr_beat && hdr_err != 3'd0) err_n = hdr_err;
      else if (in_last && !complete)   err_n = 3'd5;
      else if (in_last && sum_n != 8'd0) err_n = 3'd6;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_TOP;
      pos       <= '0;
      sh_start  <= '0;
      sh_cnt    <= 2'd0;
      sh_type   <= 8'd0;
      sh_rsvd   <= 8'd0;
      sh_lo     <= 8'd0;
      sum       <= 8'd0;
      rem       <= 16'd0;
      err       <= 3'd0;
      done      <= 1'b0;
      pass      <= 1'b0;
      err_code  <= 3'd0;
      idx_count <= '0;
      for (int i = 0; i < IDX_DEPTH; i++) begin
        off_mem[i] <= '0;
        len_mem[i] <= 16'd0;
      end
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        sum <= sum_n;
        pos <= pos + 1'b1;
        err <= err_n;
        case (ph)
          PH_TOP: if (pos == OFF_W'(15)) begin
            ph     <= PH_SUBH;
            sh_cnt <= 2'd0;
          end
          PH_SUBH: begin
            sh_cnt <= sh_cnt + 1'b1;
            case (sh_cnt)
              2'd0: begin sh_start <= pos; sh_type <= in_byte; end
              2'd1: sh_rsvd <= in_byte;
              2'd2: sh_lo <= in_byte;
              default: begin
                rem <= (new_len > 16'd4) ? new_len - 16'd4 : 16'd0;
                if (new_len > 16'd4) ph <= PH_BODY;
              end
            endcase
          end
          PH_BODY: begin
            rem <= rem - 1'b1;
            if (rem == 16'd1) ph <= PH_SUBH;
          end
          default: ph <= PH_TOP;
        endcase
        if (ph == PH_TOP && pos == '0) begin
          off_mem[0] <= '0;
          len_mem[0] <= 16'd16;
          idx_count  <= CW'(1);
        end
        if (wr_sub) begin
          off_mem[idx_count[AW-1:0]] <= sh_start;
          len_mem[idx_count[AW-1:0]] <= new_len;
          idx_count <= idx_count + 1'b1;
        end
        if (in_last) begin
          done     <= 1'b1;
          err_code <= err_n;
          pass     <= (err_n == 3'd0);
          pos      <= '0;
          ph       <= PH_TOP;
          sum      <= 8'd0;
          err      <= 3'd0;
          sh_cnt   <= 2'd0;
          rem      <= 16'd0;
        end
      end
    end
  end
endmodule

module attr_table_checker_sva #(
  parameter int IDX_DEPTH = 8,
  localparam int CW = $clog2(IDX_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_last,
  input logic          done,
  input logic          pass,
  input logic [2:0]    err_code,
  input logic [CW-1:0] idx_count
);
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> done); // R11
  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last)); // R11
  AST_PASS_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (err_code == 3'd0))); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($stable(err_code) || done)); // R11
  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_count <= CW'(IDX_DEPTH)); // R9
  AST_HEADER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idx_count != '0)); // R1
endmodule

bind attr_table_checker attr_table_checker_sva #(.IDX_DEPTH(IDX_DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .done(done), .pass(pass), .err_code(err_code), .idx_count(idx_count)
);

// File: tb/sim_attr_table_checker.sv
module sim_attr_table_checker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic        in_last = 1'b0;
  logic        done, pass;
  logic [2:0]  err_code;
  logic [3:0]  idx_count;
  logic [2:0]  idx_rd_addr = 3'd0;
  logic [15:0] idx_rd_off, idx_rd_len;

  int n_chk = 0, n_bad = 0;
  logic [7:0] sbuf [0:1023];
  int slen, tbase, n_ent;
  int eoff [0:15];
  int elen [0:15];
  bit finished = 0;

  attr_table_checker #(.IDX_DEPTH(DEPTH), .OFF_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .done(done), .pass(pass), .err_code(err_code),
    .idx_count(idx_count), .idx_rd_addr(idx_rd_addr),
    .idx_rd_off(idx_rd_off), .idx_rd_len(idx_rd_len));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic begin_table();
    tbase = slen;
    for (int i = 0; i < 16; i++) sbuf[slen + i] = 8'h00;
    sbuf[slen + 4] = 8'h01;
    sbuf[slen + 12] = 8'h2A;
    slen += 16;
    n_ent = 1;
    eoff[0] = 0;
    elen[0] = 16;
  endtask

  task automatic add_sub(input int t, input int rsv, input int len, input bit rec);
    if (rec) begin
      eoff[n_ent] = slen - tbase;
      elen[n_ent] = len;
      n_ent++;
    end
    sbuf[slen] = 8'(t);
    sbuf[slen + 1] = 8'(rsv);
    sbuf[slen + 2] = 8'(len);
    sbuf[slen + 3] = 8'(len >> 8);
    slen += 4;
    for (int i = 4; i < len; i++) begin
      sbuf[slen] = 8'(slen * 7 + 3);
      slen++;
    end
  endtask

  task automatic finish_table(input bit bad_sum);
    logic [7:0] s;
    int tl;
    tl = slen - tbase;
    sbuf[tbase] = 8'(tl);
    sbuf[tbase + 1] = 8'(tl >> 8);
    sbuf[tbase + 2] = 8'h00;
    sbuf[tbase + 3] = 8'h00;
    sbuf[tbase + 5] = 8'h00;
    s = 8'h00;
    for (int i = tbase; i < slen; i++) s = s + sbuf[i];
    sbuf[tbase + 5] = 8'h00 - s;
    if (bad_sum) sbuf[tbase + 5] = sbuf[tbase + 5] ^ 8'h01;
  endtask

  task automatic send(input int first, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = sbuf[first + i];
      in_last = (i == cnt - 1);
    end
  endtask

  task automatic result(input int exp, input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    chk(done === 1'b1, {tag, " done"}, int'(done), 1);
    chk(err_code === 3'(exp), {tag, " err_code"}, int'(err_code), exp);
    chk(pass === (exp == 0), {tag, " pass"}, int'(pass), int'(exp == 0));
  endtask

  task automatic check_index(input string tag);
    chk(idx_count === 4'(n_ent), {tag, " idx_count"}, int'(idx_count), n_ent);
    for (int e = 0; e < n_ent; e++) begin
      idx_rd_addr = 3'(e);
      #1;
      chk(idx_rd_off === 16'(eoff[e]), {tag, " offset"}, int'(idx_rd_off), eoff[e]);
      chk(idx_rd_len === 16'(elen[e]), {tag, " length"}, int'(idx_rd_len), elen[e]);
    end
  endtask

  task automatic one_table(input int exp, input string tag);
    send(tbase, slen - tbase);
    result(exp, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done === 1'b0, "R11 reset done", int'(done), 0);
    chk(pass === 1'b0, "R11 reset pass", int'(pass), 0);
    chk(err_code === 3'd0, "R11 reset err_code", int'(err_code), 0);
    chk(idx_count === 4'd0, "R11 reset idx_count", int'(idx_count), 0);
  endtask

  task automatic t_all_types();
    slen = 0; begin_table();
    add_sub(0, 0, 24, 1); add_sub(1, 0, 24, 1); add_sub(2, 0, 20, 1);
    add_sub(3, 0, 8, 1);  add_sub(4, 0, 24, 1); add_sub(5, 0, 32, 1);
    finish_table(0);
    one_table(0, "R2 all types pass");
    check_index("R1 index");
    @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", int'(done), 0);
    chk(pass === 1'b1, "R11 pass held", int'(pass), 1);
  endtask

  task automatic t_type5();
    slen = 0; begin_table(); add_sub(5, 0, 16, 1); finish_table(0);
    one_table(0, "R3 type5 min");
    slen = 0; begin_table(); add_sub(5, 0, 20, 0); finish_table(0);
    one_table(3, "R3 type5 partial record");
    slen = 0; begin_table(); add_sub(5, 0, 8, 0); finish_table(0);
    one_table(3, "R3 type5 short");
  endtask

  task automatic t_mismatch();
    slen = 0; begin_table(); add_sub(2, 0, 24, 0); finish_table(0);
    one_table(3, "R2 type2 len24");
    slen = 0; begin_table(); add_sub(3, 0, 12, 0); finish_table(0);
    one_table(3, "R2 type3 len12");
  endtask

  task automatic t_zero_len();
    slen = 0; begin_table(); add_sub(3, 0, 8, 1); add_sub(0, 0, 0, 0); finish_table(0);
    one_table(1, "R4 zero length");
  endtask

  task automatic t_rsvd();
    slen = 0; begin_table(); add_sub(4, 8'h80, 24, 0); finish_table(0);
    one_table(2, "R5 reserved byte");
  endtask

  task automatic t_rtype();
    slen = 0; begin_table(); add_sub(6, 0, 8, 0); finish_table(0);
    one_table(4, "R6 type 6");
    slen = 0; begin_table(); add_sub(8'hFF, 0, 8, 0); finish_table(0);
    one_table(4, "R6 type 255");
  endtask

  task automatic t_overrun();
    slen = 0; begin_table(); add_sub(3, 0, 8, 1); finish_table(0);
    send(0, slen - 3);
    result(5, "R7 cut in body");
    send(0, 10);
    result(5, "R7 cut in table header");
    send(0, 18);
    result(5, "R7 cut in sub header");
  endtask

  task automatic t_sum();
    slen = 0; begin_table(); add_sub(1, 0, 24, 1); finish_table(1);
    one_table(6, "R8 bad checksum");
    slen = 0; begin_table(); finish_table(0);
    one_table(0, "R8 header only good");
  endtask

  task automatic t_overflow();
    slen = 0; begin_table();
    for (int k = 0; k < DEPTH; k++) add_sub(3, 0, 8, k < DEPTH - 1);
    finish_table(0);
    one_table(7, "R9 index overflow");
    check_index("R9 index after overflow");
  endtask

  task automatic t_first();
    slen = 0; begin_table(); add_sub(2, 1, 20, 0); add_sub(7, 0, 8, 0); finish_table(1);
    one_table(2, "R10 first error kept");
    slen = 0; begin_table(); add_sub(9, 1, 0, 0); finish_table(0);
    one_table(1, "R10 zero length precedes");
    slen = 0; begin_table(); add_sub(9, 1, 8, 0); finish_table(0);
    one_table(2, "R10 reserved byte precedes type");
  endtask

  task automatic t_back_to_back();
    int a0, a1;
    slen = 0; begin_table(); add_sub(6, 0, 8, 0); finish_table(0);
    a0 = 0; a1 = slen;
    begin_table(); add_sub(2, 0, 20, 1); add_sub(0, 0, 24, 1); finish_table(0);
    send(a0, a1);
    send(a1, slen - a1);
    result(0, "R12 clean restart");
    check_index("R12 index restart");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_types();
    t_type5();
    t_mismatch();
    t_zero_len();
    t_rsvd();
    t_rtype();
    t_overrun();
    t_sum();
    t_overflow();
    t_first();
    t_back_to_back();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule